// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

This block is a 16-bit up-counter with an 8-bit control register that software can write either whole or one bit at a time. The counter advances on a qualified internal tick or on falling edges of an external count pin. It has two working styles. In the first, the counter reloads itself from a 16-bit capture/reload register. In the second, a falling edge on an external trigger pin copies the live count into that register.

An overflow flag and an external-event flag together raise a single interrupt request. The counter can also serve as a baud-rate generator for a serial port. Its wrap pulse can then replace the alternate transmit tick, the alternate receive tick, or both. While it serves as a baud generator, the overflow flag is never set.

The external pins go through two-flop synchronizers. Software can load the counter and the capture/reload register directly.

Top module: `cr_timer16`

## Requirements
- R1: After reset the control register, the count and the capture/reload register are all 0, and `irq`, `tx_baud_tick` and `rx_baud_tick` are 0.
- R2: While the run bit (control bit 2) is 0, the count holds its value whatever ticks or pin edges arrive.
- R3: With the count-source bit (bit 1) at 0, each clock with `tick_int` high adds one. With bit 1 at 1, `tick_int` is ignored and each falling edge of `cnt_pin` adds exactly one. The increment shows three clocks after the pin falls.
- R4: With the capture bit (bit 0) at 0 and no baud select set, a count of FFFFh that receives an increment loads the capture/reload value and sets the overflow flag (bit 7).
- R5: With the capture bit at 1 and no baud select set, a count of FFFFh that receives an increment wraps to 0000h and sets the overflow flag.
- R6: With the trigger enable (bit 3) at 1, the capture bit at 0 and no baud select set, a falling edge of `trig_pin` loads the count from the capture/reload register and sets the external flag (bit 6). The effect shows three clocks after the pin falls.
- R7: With the trigger enable at 1, the capture bit at 1 and no baud select set, a falling edge of `trig_pin` copies the count present before that clock edge into the capture/reload register. The counter keeps incrementing in the same cycle.
- R8: With the trigger enable at 0, a falling edge of `trig_pin` changes neither the count, nor the capture/reload register, nor the external flag.
- R9: While the receive-baud select (bit 5) or the transmit-baud select (bit 4) is 1, an overflow always reloads and never sets the overflow flag. An enabled trigger edge then sets the external flag and changes neither the count nor the capture/reload register.
- R10: One clock after any cycle, `rx_baud_tick` equals the counter's wrap pulse of that cycle if bit 5 is 1, and `alt_rx_tick` otherwise. `tx_baud_tick` does the same with bit 4 and `alt_tx_tick`.
- R11: `irq` is 1 exactly when the overflow flag or the external flag is 1.
- R12: A software write of 0 to a flag clears it and a write of 1 sets it. A hardware set in the same cycle as a software clear leaves the flag set.
- R13: A bit write changes only control bit `bit_sel` to `bit_wdata`, with bit 0 the capture bit and bit 7 the overflow flag.
- R14: `cnt_we` loads `cnt_wdata` into the count and takes priority over an increment or a reload in the same cycle. `crr_we` loads the capture/reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Whole-byte write of the control register |
| ctl_wdata | input | 8 | Data for the whole-byte write |
| bit_we | input | 1 | Single-bit write of the control register |
| bit_sel | input | 3 | Bit number for the single-bit write |
| bit_wdata | input | 1 | Value for the single-bit write |
| ctl_rdata | output | 8 | Current control register |
| cnt_we | input | 1 | Load the count |
| cnt_wdata | input | 16 | Value to load into the count |
| crr_we | input | 1 | Load the capture/reload register |
| crr_wdata | input | 16 | Value to load into the capture/reload register |
| count | output | 16 | Current count |
| crr_value | output | 16 | Current capture/reload register |
| tick_int | input | 1 | Internal count qualifier |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| trig_pin | input | 1 | External trigger pin (asynchronous) |
| alt_tx_tick | input | 1 | Alternate transmit baud tick |
| alt_rx_tick | input | 1 | Alternate receive baud tick |
| tx_baud_tick | output | 1 | Transmit baud tick enable |
| rx_baud_tick | output | 1 | Receive baud tick enable |
| irq | output | 1 | Interrupt request |

## Verification
A hardware flag set and a software clear of the same flag can land on the same clock edge. The bench provokes this by presenting a count of FFFFh with an increment, in the cycle where a bit write clears the overflow flag. The flag must read 1 afterwards, and a later clear on its own must leave it at 0. Two other collisions are judged by the values read back after the edge: a trigger capture in the same cycle as an increment, and a count load in the same cycle as an increment.

// File: rtl/cr_timer_pkg.sv
// Package: shared widths, control-bit positions and the control register
// layout for the capture/reload timer-counter.
package cr_timer_pkg;
    localparam int CNT_W   = 16;
    localparam int CTL_W   = 8;
    localparam int BSEL_W  = $clog2(CTL_W);

    // Bit numbers used by the single-bit write port.
    localparam int B_CAP   = 0;
    localparam int B_SRC   = 1;
    localparam int B_RUN   = 2;
    localparam int B_TEN   = 3;
    localparam int B_TXB   = 4;
    localparam int B_RXB   = 5;
    localparam int B_EXT   = 6;
    localparam int B_OVF   = 7;

    // Control register, MSB first.
    typedef struct packed {
        logic ovf_flag;   // 7
        logic ext_flag;   // 6
        logic rx_baud;    // 5
        logic tx_baud;    // 4
        logic trig_en;    // 3
        logic run;        // 2
        logic src_pin;    // 1
        logic cap_mode;   // 0
    } ctl_t;
endpackage

// File: rtl/crt_edge_fall.sv
// Module: crt_edge_fall
// Brings an asynchronous pin into the clock domain through STAGES flops and
// flags a 1-to-0 change for a single cycle.
// Assumes: the pin stays at each level for at least two clocks; the flops
// reset to 0, so a pin that is already high after reset gives no event.
module crt_edge_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Synchronizer chain and previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Falling edge: the old sample was high and the new one is low.
    always_comb fall_o = prev_q & ~sync_q[STAGES-1];

    // R3: an edge gives a single one-cycle event.
    a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/crt_ctrl_reg.sv
// Module: crt_ctrl_reg
// Holds the 8-bit control register. Accepts whole-byte and single-bit
// software writes, and merges in the hardware flag sets.
// Assumes: if both writes come in one cycle, the bit write is applied on
// top of the byte write; a hardware set always beats software.
module crt_ctrl_reg
    import cr_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [CTL_W-1:0]  byte_wdata,
    input  logic              bit_we,
    input  logic [BSEL_W-1:0] bit_sel,
    input  logic              bit_wdata,
    input  logic              ovf_set,
    input  logic              ext_set,
    output ctl_t              ctl_o
);
    ctl_t ctl_q;
    logic [CTL_W-1:0] sw_next;

    // Software view of the next value: byte write first, then the bit write.
    always_comb begin
        sw_next = ctl_q;
        if (byte_we) sw_next = byte_wdata;
        if (bit_we)  sw_next[bit_sel] = bit_wdata;
    end

    // Register update; hardware sets are ORed in last so they win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q          <= ctl_t'(sw_next);
            ctl_q.ovf_flag <= sw_next[B_OVF] | ovf_set;
            ctl_q.ext_flag <= sw_next[B_EXT] | ext_set;
        end
    end

    always_comb ctl_o = ctl_q;

    // R12: a hardware set leaves the flag at 1 whatever software did.
    a_r12_ovf_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ctl_q.ovf_flag);
    a_r12_ext_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ext_set |=> ctl_q.ext_flag);
    // R9: the overflow flag is never raised while a baud select is on.
    a_r9_no_ovf_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |-> !(ctl_q.rx_baud || ctl_q.tx_baud));
endmodule

// File: rtl/crt_counter.sv
// Module: crt_counter
// Holds the up-counter and the capture/reload register, and decides between
// reload, capture and wrap.
// Assumes: inc is already qualified by the run bit; a software count load
// takes priority over everything else; a capture takes the count from
// before the edge while the counter still increments.
module crt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         trig_ev,
    input  logic         cap_mode,
    input  logic         baud,
    input  logic         cnt_we,
    input  logic [W-1:0] cnt_wdata,
    input  logic         crr_we,
    input  logic [W-1:0] crr_wdata,
    output logic [W-1:0] count_o,
    output logic [W-1:0] crr_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic [W-1:0] cnt_q, crr_q;
    logic         reload, capture;

    // Event decode: overflow and trigger turned into reload or capture.
    always_comb begin
        wrap_o  = inc && (cnt_q == ALL_ONES);
        reload  = (wrap_o && (baud || !cap_mode)) ||
                  (trig_ev && !cap_mode && !baud);
        capture = trig_ev && cap_mode && !baud;
    end

    // Counter: load > reload > increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_we)  cnt_q <= cnt_wdata;
        else if (reload)  cnt_q <= crr_q;
        else if (inc)     cnt_q <= cnt_q + 1'b1;
    end

    // Capture/reload register: a capture beats a software load.
    always_ff @(posedge clk) begin
        if (!rst_n)       crr_q <= '0;
        else if (capture) crr_q <= cnt_q;
        else if (crr_we)  crr_q <= crr_wdata;
    end

    always_comb begin
        count_o = cnt_q;
        crr_o   = crr_q;
    end

    // R2: nothing that could move the count leaves it unchanged.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !cnt_we && !trig_ev) |=> $stable(cnt_q));
    // R4: a reload takes the capture/reload value.
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && !cnt_we) |=> cnt_q == $past(crr_q));
    // R5: an overflow in capture mode wraps to zero.
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && cap_mode && !baud && !trig_ev && !cnt_we) |=> cnt_q == '0);
    // R7: a capture keeps the count seen before the edge.
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> crr_q == $past(cnt_q));
endmodule

// File: rtl/crt_baud_out.sv
// Module: crt_baud_out
// Registered selection of each baud tick: the counter wrap pulse or the
// alternate tick, with one select bit per channel.
// Assumes: channel 0 is transmit and channel 1 is receive.
module crt_baud_out #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap,
    input  logic [CH-1:0] sel,
    input  logic [CH-1:0] alt_tick,
    output logic [CH-1:0] tick_o
);
    for (genvar i = 0; i < CH; i++) begin : g_ch
        // Per-channel tick register.
        always_ff @(posedge clk) begin
            if (!rst_n) tick_o[i] <= 1'b0;
            else        tick_o[i] <= sel[i] ? wrap : alt_tick[i];
        end

        // R10: a selected wrap shows as a tick one clock later.
        a_r10_wrap_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[i] && wrap) |=> tick_o[i]);
        // R10: an unselected channel follows its alternate tick.
        a_r10_alt_tick: assert property (@(posedge clk) disable iff (!rst_n)
            !sel[i] |=> tick_o[i] == $past(alt_tick[i]));
    end
endmodule

// File: rtl/cr_timer16.sv
// Module: cr_timer16 (top)
// 16-bit capture/reload timer-counter with a bit-writable control register,
// synchronized count and trigger pins, two flags with one interrupt, and
// baud tick outputs.
// Assumes: the pins are asynchronous and slow next to clk; tick_int is a
// one-cycle enable coming from the clock domain.
module cr_timer16
    import cr_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              bit_we,
    input  logic [BSEL_W-1:0] bit_sel,
    input  logic              bit_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic              crr_we,
    input  logic [CNT_W-1:0]  crr_wdata,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  crr_value,
    input  logic              tick_int,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              alt_tx_tick,
    input  logic              alt_rx_tick,
    output logic              tx_baud_tick,
    output logic              rx_baud_tick,
    output logic              irq
);
    localparam int NPIN = 2;   // 0: count pin, 1: trigger pin

    ctl_t            ctl;
    logic [NPIN-1:0] pins, falls;
    logic            inc, trig_ev, baud, wrap;
    logic [1:0]      tick_pair;

    always_comb pins = {trig_pin, cnt_pin};

    // One synchronizer and edge detector per external pin.
    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        crt_edge_fall #(.STAGES(2)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (pins[p]),
            .fall_o (falls[p])
        );
    end

    // Qualified increment, trigger event and baud-mode decode.
    always_comb begin
        baud    = ctl.rx_baud | ctl.tx_baud;
        inc     = ctl.run & (ctl.src_pin ? falls[0] : tick_int);
        trig_ev = ctl.trig_en & falls[1];
    end

    crt_ctrl_reg u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_we    (ctl_we),
        .byte_wdata (ctl_wdata),
        .bit_we     (bit_we),
        .bit_sel    (bit_sel),
        .bit_wdata  (bit_wdata),
        .ovf_set    (wrap & ~baud),
        .ext_set    (trig_ev),
        .ctl_o      (ctl)
    );

    crt_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (inc),
        .trig_ev   (trig_ev),
        .cap_mode  (ctl.cap_mode),
        .baud      (baud),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .crr_we    (crr_we),
        .crr_wdata (crr_wdata),
        .count_o   (count),
        .crr_o     (crr_value),
        .wrap_o    (wrap)
    );

    crt_baud_out #(.CH(2)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .sel      ({ctl.rx_baud, ctl.tx_baud}),
        .alt_tick ({alt_rx_tick, alt_tx_tick}),
        .tick_o   (tick_pair)
    );

    // Output assembly: register readback, baud ticks and interrupt.
    always_comb begin
        ctl_rdata    = ctl;
        tx_baud_tick = tick_pair[0];
        rx_baud_tick = tick_pair[1];
        irq          = ctl.ovf_flag | ctl.ext_flag;
    end

    // R8: a disabled trigger never sets the external flag.
    a_r8_trig_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.trig_en && !ctl.ext_flag && !ctl_we && !bit_we) |=> !ctl.ext_flag);
endmodule

// File: tb/cr_timer16_tb.sv
// Directed bench for cr_timer16: one task per scenario.
module cr_timer16_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 0, bit_we = 0, bit_wdata = 0;
    logic [7:0]  ctl_wdata = 0;
    logic [2:0]  bit_sel = 0;
    logic        cnt_we = 0, crr_we = 0;
    logic [15:0] cnt_wdata = 0, crr_wdata = 0;
    logic        tick_int = 0, cnt_pin = 1, trig_pin = 1;
    logic        alt_tx_tick = 0, alt_rx_tick = 0;
    logic [7:0]  ctl_rdata;
    logic [15:0] count, crr_value;
    logic        tx_baud_tick, rx_baud_tick, irq;

    int runs = 0, fails = 0;

    always #5 clk = ~clk;

    cr_timer16 u_dut (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        runs++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1; ctl_wdata = v;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic wr_cnt(input logic [15:0] v);
        @(negedge clk); cnt_we = 1; cnt_wdata = v;
        @(negedge clk); cnt_we = 0;
    endtask

    task automatic wr_crr(input logic [15:0] v);
        @(negedge clk); crr_we = 1; crr_wdata = v;
        @(negedge clk); crr_we = 0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_int = 1;
        repeat (n) @(negedge clk);
        tick_int = 0;
    endtask

    // Drop the trigger pin, wait for the synchronized effect, raise it again.
    task automatic trig_pulse();
        @(negedge clk); trig_pin = 0;
        repeat (4) @(negedge clk);
        trig_pin = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ctl", ctl_rdata, 0);
        chk("R1 count", count, 0);
        chk("R1 crr", crr_value, 0);
        chk("R1 irq/ticks", {irq, tx_baud_tick, rx_baud_tick}, 0);
    endtask

    task automatic t_bitwrite();
        wr_ctl(8'h00);
        @(negedge clk); bit_we = 1; bit_sel = 3'd2; bit_wdata = 1;
        @(negedge clk); bit_we = 0;
        chk("R13 run bit only", ctl_rdata, 8'h04);
    endtask

    task automatic t_hold_and_count();
        wr_ctl(8'h00); wr_cnt(16'h0010);
        ticks(5);
        chk("R2 hold when stopped", count, 16'h0010);
        wr_ctl(8'h04);
        ticks(5);
        chk("R3 internal ticks", count, 16'h0015);
        // R14: load in the same cycle as a tick wins.
        @(negedge clk); tick_int = 1; cnt_we = 1; cnt_wdata = 16'h0200;
        @(negedge clk); tick_int = 0; cnt_we = 0;
        chk("R14 load beats increment", count, 16'h0200);
    endtask

    task automatic t_pin_count();
        wr_ctl(8'h06); wr_cnt(16'h0000);
        tick_int = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); cnt_pin = 0;
            repeat (4) @(negedge clk);
            cnt_pin = 1;
            repeat (4) @(negedge clk);
        end
        tick_int = 0;
        chk("R3 pin edges only", count, 16'h0003);
    endtask

    task automatic t_reload_ovf();
        wr_ctl(8'h04); wr_crr(16'h1234); wr_cnt(16'hFFFE);
        ticks(2);
        chk("R4 reload value", count, 16'h1234);
        chk("R4 ovf flag", ctl_rdata[7], 1);
        chk("R11 irq", irq, 1);
        wr_ctl(8'h04);
        chk("R12 sw clear", ctl_rdata[7], 0);
        chk("R11 irq low", irq, 0);
    endtask

    task automatic t_wrap_capmode();
        wr_ctl(8'h05); wr_crr(16'h4444); wr_cnt(16'hFFFF);
        ticks(1);
        chk("R5 wrap to zero", count, 16'h0000);
        chk("R5 ovf flag", ctl_rdata[7], 1);
    endtask

    task automatic t_trig_reload();
        wr_ctl(8'h08); wr_cnt(16'h0055); wr_crr(16'h7777);
        trig_pulse();
        chk("R6 trig reload", count, 16'h7777);
        chk("R6 ext flag", ctl_rdata[6], 1);
        chk("R11 irq ext", irq, 1);
    endtask

    task automatic t_trig_disabled();
        wr_ctl(8'h00); wr_cnt(16'h0055); wr_crr(16'h7777);
        trig_pulse();
        chk("R8 count untouched", count, 16'h0055);
        chk("R8 no ext flag", ctl_rdata[6], 0);
    endtask

    task automatic t_capture();
        wr_ctl(8'h0D); wr_cnt(16'h0100); wr_crr(16'h0000);
        @(negedge clk); tick_int = 1; trig_pin = 0;
        repeat (3) @(negedge clk);
        tick_int = 0;
        chk("R7 captured value", crr_value, 16'h0102);
        chk("R7 counter runs on", count, 16'h0103);
        chk("R7 ext flag", ctl_rdata[6], 1);
        repeat (2) @(negedge clk); trig_pin = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_baud();
        wr_ctl(8'h24); wr_crr(16'hABCD); wr_cnt(16'hFFFF);
        @(negedge clk); tick_int = 1;
        @(negedge clk); tick_int = 0;
        chk("R9 baud reload", count, 16'hABCD);
        chk("R10 rx tick from wrap", rx_baud_tick, 1);
        chk("R10 tx follows alt", tx_baud_tick, 0);
        chk("R9 no ovf flag", ctl_rdata[7], 0);
        @(negedge clk);
        chk("R10 rx tick one cycle", rx_baud_tick, 0);
        alt_tx_tick = 1;
        @(negedge clk); alt_tx_tick = 0;
        chk("R10 alt tx passes", tx_baud_tick, 1);
        // R9: trigger in baud mode sets flag only.
        wr_ctl(8'h2C); wr_cnt(16'h0022); wr_crr(16'h9999);
        trig_pulse();
        chk("R9 trig no reload", count, 16'h0022);
        chk("R9 trig no capture", crr_value, 16'h9999);
        chk("R9 trig ext flag", ctl_rdata[6], 1);
    endtask

    task automatic t_collision();
        wr_ctl(8'h04); wr_cnt(16'hFFFF);
        @(negedge clk); bit_we = 1; bit_sel = 3'd7; bit_wdata = 1;
        @(negedge clk); bit_we = 0;
        chk("R12 sw set", ctl_rdata[7], 1);
        wr_cnt(16'hFFFF);
        @(negedge clk); tick_int = 1; bit_we = 1; bit_sel = 3'd7; bit_wdata = 0;
        @(negedge clk); tick_int = 0; bit_we = 0;
        chk("R12 hw set beats clear", ctl_rdata[7], 1);
        @(negedge clk); bit_we = 1; bit_sel = 3'd7; bit_wdata = 0;
        @(negedge clk); bit_we = 0;
        chk("R12 clear alone", ctl_rdata[7], 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bitwrite();
        t_hold_and_count();
        t_pin_count();
        t_reload_ovf();
        t_wrap_capmode();
        t_trig_reload();
        t_trig_disabled();
        t_capture();
        t_baud();
        t_collision();
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule